// File: doc/BRIEF.md
# Seconds Counter with Deferred-Update Alarm

This block is a memory-mapped real-time clock. It keeps a 32-bit count of elapsed seconds and advances it on each one-cycle `tick` strobe, which the surrounding chip produces once per second. Software sets the time through a separate load register, programs an alarm threshold, enables the interrupt with a one-bit mask, and acknowledges the interrupt by writing to the interrupt status register.

Writes to the load, alarm, mask and acknowledge registers do not act at once. Each write queues an operation that completes on the second `tick` after the write. This models the transfer of the value into a slow clock domain. While an operation is queued, a matching flag in the status register reads 1, so software can poll until the update has landed. The bus is a plain word-wide register port. Reads are combinational and writes are taken on the clock edge where `bus_we` is high.

Top module: `sec_rtc`

## Requirements
- R1: The time register at byte offset 0x00 reads the seconds count. The count is 0 after reset, rises by exactly one on each `tick` and does not move without one. It wraps from 0xFFFFFFFF to 0.
- R2: Writes to offset 0x00 are ignored, and the count keeps advancing from its previous value.
- R3: A write to the load register at offset 0x08 replaces the count on the second `tick` after the write. The first `tick` still increments the count.
- R4: Reading offset 0x08 returns the last value written there (0 after reset), not the current count.
- R5: A second write to a register whose operation is still queued replaces the queued value. It does not delay the completion tick.
- R6: The alarm register at offset 0x04 reads back the last value written (0xFFFFFFFF after reset). A written alarm takes effect on the second `tick`. Once the count is strictly greater than the effective alarm, an interrupt condition is latched.
- R7: The mask register at offset 0x0C is bit 0 only (0 after reset) and takes effect on the second `tick` after a write. The `irq` output, and bit 0 read at offset 0x10, both equal the latched condition ANDed with the effective mask. A latched condition survives while the mask is 0.
- R8: Writing a word with bit 0 set to offset 0x10 acknowledges the interrupt. The latched condition clears on the second `tick` after the write. It latches again only after a newly written alarm has taken effect and is then passed. A write with bit 0 clear is ignored.
- R9: The status register at offset 0x14 carries four pending flags: bit 0 for load, bit 1 for alarm, bit 2 for acknowledge and bit 3 for mask. A flag reads 1 from the write until its operation completes, and reads 0 after that.
- R10: Reads of unused word offsets (0x18 and above), or of addresses whose two low bits are not zero, return 0. Writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit count, a 5-bit address and a two-tick settle delay. At these values each queued operation can be watched through both of its ticks: the flag is still set after the first tick and clear after the second. The full 32-bit width is still exercised, because the load register can place the count two seconds before the wrap point. Alarm tests sit right at the strict-greater-than boundary, at equality and one second past it. They run with the mask on and off, and before and after a fresh alarm re-arms the latch.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int NUM_OPS = 4;

    // Operation indices; each also selects its bit in the status word.
    localparam int OP_LOAD  = 0;
    localparam int OP_ALARM = 1;
    localparam int OP_ACK   = 2;
    localparam int OP_MASK  = 3;

    typedef enum logic [2:0] {
        SEL_TIME  = 3'd0,
        SEL_ALARM = 3'd1,
        SEL_LOAD  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_ISTAT = 3'd4,
        SEL_STAT  = 3'd5,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // Maps a byte address to a register select; misaligned or unused gives SEL_NONE.
    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (byte_addr[1:0] == 2'b00) begin
            case (byte_addr[31:2])
                30'd0:   sel = SEL_TIME;
                30'd1:   sel = SEL_ALARM;
                30'd2:   sel = SEL_LOAD;
                30'd3:   sel = SEL_MASK;
                30'd4:   sel = SEL_ISTAT;
                30'd5:   sel = SEL_STAT;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/sec_rtc_defer.sv
// One queued register update: holds the last written value and fires
// on the SETTLE_TICKS-th tick after the write that opened it.
module sec_rtc_defer #(
    parameter int W = 32,
    parameter int SETTLE_TICKS = 2,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         pending,
    output logic         fire,
    output logic [W-1:0] val
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(1);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     val_q;

    assign fire    = pend_q && tick && (cnt_q == CNT_LAST);
    assign pending = pend_q;
    assign val     = val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            val_q  <= RESET_VAL;
        end else begin
            if (fire) begin
                pend_q <= 1'b0;
            end else if (pend_q && tick) begin
                cnt_q <= cnt_q - CNT_LAST;
            end
            if (wr) begin
                val_q  <= wdata;
                pend_q <= 1'b1;
                // A rewrite of a live operation keeps its countdown.
                if (!pend_q || fire) begin
                    cnt_q <= CNT_START;
                end
            end
        end
    end

    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend_q);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        fire && !wr |=> !pend_q);

    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        pend_q && !tick && !wr |=> $stable(cnt_q) && pend_q);

    a_r4_value_kept: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(val_q));

endmodule

// File: rtl/sec_rtc_core.sv
// Seconds counter, effective alarm and mask, and the latched interrupt.
module sec_rtc_core
    import sec_rtc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_OPS-1:0] fire,
    input  logic [DATA_W-1:0]  load_val,
    input  logic [DATA_W-1:0]  alarm_val,
    input  logic               ack_val,
    input  logic               mask_val,
    output logic [DATA_W-1:0]  count,
    output logic               irq
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] alarm_q;
    logic              armed_q;
    logic              hit_q;
    logic              mask_q;
    logic              passed;

    assign passed = count_q > alarm_q;
    assign count  = count_q;
    assign irq    = hit_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            alarm_q <= '1;
            armed_q <= 1'b1;
            hit_q   <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            if (tick) begin
                count_q <= fire[OP_LOAD] ? load_val : count_q + ONE;
            end
            if (fire[OP_ALARM]) begin
                alarm_q <= alarm_val;
            end
            if (fire[OP_MASK]) begin
                mask_q <= mask_val;
            end
            if (fire[OP_ACK] && ack_val) begin
                hit_q <= 1'b0;
            end
            if (fire[OP_ALARM]) begin
                armed_q <= 1'b1;
            end else if (armed_q && passed) begin
                hit_q   <= 1'b1;
                armed_q <= 1'b0;
            end
        end
    end

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        tick && !fire[OP_LOAD] |=> count_q == $past(count_q) + ONE);

    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        fire[OP_LOAD] |=> count_q == $past(load_val));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        fire[OP_ACK] && !armed_q |=> !hit_q);

    a_r6_latch: assert property (@(posedge clk) disable iff (rst)
        hit_q && !fire[OP_ACK] |=> hit_q);

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int SETTLE_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    reg_sel_e           sel;
    logic [NUM_OPS-1:0] op_wr;
    logic [NUM_OPS-1:0] op_pend;
    logic [NUM_OPS-1:0] op_fire;
    logic [DATA_W-1:0]  op_val [NUM_OPS];
    logic [DATA_W-1:0]  count;

    assign sel = decode_addr(32'(bus_addr));

    always_comb begin
        op_wr           = '0;
        op_wr[OP_LOAD]  = bus_we && (sel == SEL_LOAD);
        op_wr[OP_ALARM] = bus_we && (sel == SEL_ALARM);
        op_wr[OP_MASK]  = bus_we && (sel == SEL_MASK);
        op_wr[OP_ACK]   = bus_we && (sel == SEL_ISTAT) && bus_wdata[0];
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        localparam int OW = (i == OP_MASK || i == OP_ACK) ? 1 : DATA_W;
        localparam logic [OW-1:0] RV = (i == OP_ALARM) ? {OW{1'b1}} : {OW{1'b0}};
        logic [OW-1:0] val_w;

        sec_rtc_defer #(
            .W(OW),
            .SETTLE_TICKS(SETTLE_TICKS),
            .RESET_VAL(RV)
        ) u_defer (
            .clk(clk),
            .rst(rst),
            .tick(tick),
            .wr(op_wr[i]),
            .wdata(bus_wdata[OW-1:0]),
            .pending(op_pend[i]),
            .fire(op_fire[i]),
            .val(val_w)
        );

        assign op_val[i] = DATA_W'(val_w);
    end

    sec_rtc_core #(
        .DATA_W(DATA_W)
    ) u_core (
        .clk(clk),
        .rst(rst),
        .tick(tick),
        .fire(op_fire),
        .load_val(op_val[OP_LOAD]),
        .alarm_val(op_val[OP_ALARM]),
        .ack_val(op_val[OP_ACK][0]),
        .mask_val(op_val[OP_MASK][0]),
        .count(count),
        .irq(irq)
    );

    always_comb begin
        case (sel)
            SEL_TIME:  bus_rdata = count;
            SEL_ALARM: bus_rdata = op_val[OP_ALARM];
            SEL_LOAD:  bus_rdata = op_val[OP_LOAD];
            SEL_MASK:  bus_rdata = op_val[OP_MASK];
            SEL_ISTAT: bus_rdata = DATA_W'(irq);
            SEL_STAT:  bus_rdata = DATA_W'(op_pend);
            default:   bus_rdata = '0;
        endcase
    end

    a_r9_fire_needs_tick: assert property (@(posedge clk) disable iff (rst)
        op_fire != '0 |-> tick);

    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> op_val[OP_MASK][0] || op_pend[OP_MASK]);

endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    sec_rtc uut (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        #1;
        check(req, 32'(irq), 32'(exp));
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk_rd("R1 reset time", 5'h00, 32'd0);
        chk_rd("R9 reset status", 5'h14, 32'd0);
        chk_rd("R6 reset alarm", 5'h04, 32'hFFFF_FFFF);
        chk_rd("R4 reset load", 5'h08, 32'd0);
        chk_rd("R7 reset mask", 5'h0C, 32'd0);
        chk_rd("R7 reset istat", 5'h10, 32'd0);
        chk_irq("R7 reset irq", 1'b0);
    endtask

    task automatic t_count;
        repeat (4) @(negedge clk);
        chk_rd("R1 no tick no change", 5'h00, 32'd0);
        ticks(3);
        chk_rd("R1 three ticks", 5'h00, 32'd3);
    endtask

    task automatic t_load;
        wr(5'h08, 32'd100);
        chk_rd("R9 load pending", 5'h14, 32'h1);
        ticks(1);
        chk_rd("R3 first tick increments", 5'h00, 32'd4);
        chk_rd("R9 load still pending", 5'h14, 32'h1);
        ticks(1);
        chk_rd("R3 loaded on second tick", 5'h00, 32'd100);
        chk_rd("R9 load flag cleared", 5'h14, 32'h0);
        ticks(1);
        chk_rd("R1 count after load", 5'h00, 32'd101);
        chk_rd("R4 load reads last write", 5'h08, 32'd100);
    endtask

    task automatic t_replace;
        wr(5'h08, 32'd500);
        ticks(1);
        wr(5'h08, 32'd700);
        chk_rd("R5 still pending", 5'h14, 32'h1);
        ticks(1);
        chk_rd("R5 replaced value on original tick", 5'h00, 32'd700);
        chk_rd("R9 flag clear after replace", 5'h14, 32'h0);
    endtask

    task automatic t_alarm_mask;
        wr(5'h04, 32'd705);
        wr(5'h0C, 32'd1);
        chk_rd("R9 alarm and mask pending", 5'h14, 32'hA);
        chk_rd("R6 alarm reads last write", 5'h04, 32'd705);
        ticks(2);
        chk_rd("R9 flags cleared", 5'h14, 32'h0);
        ticks(3);
        chk_rd("R6 at alarm value", 5'h00, 32'd705);
        chk_irq("R6 equal does not fire", 1'b0);
        ticks(1);
        chk_irq("R6 passed alarm fires", 1'b1);
        chk_rd("R7 istat reads 1", 5'h10, 32'd1);
        wr(5'h0C, 32'd0);
        ticks(1);
        chk_irq("R7 mask off not yet applied", 1'b1);
        ticks(1);
        chk_irq("R7 masked irq low", 1'b0);
        chk_rd("R7 masked istat 0", 5'h10, 32'd0);
        wr(5'h0C, 32'd1);
        ticks(2);
        chk_irq("R7 latch survives mask off", 1'b1);
    endtask

    task automatic t_ack;
        wr(5'h10, 32'd1);
        chk_rd("R9 ack pending", 5'h14, 32'h4);
        ticks(1);
        chk_irq("R8 irq held before second tick", 1'b1);
        ticks(1);
        chk_irq("R8 ack cleared", 1'b0);
        chk_rd("R9 ack flag cleared", 5'h14, 32'h0);
        ticks(3);
        chk_irq("R8 no relatch on old alarm", 1'b0);
        wr(5'h10, 32'd0);
        chk_rd("R8 zero write ignored", 5'h14, 32'h0);
    endtask

    task automatic t_rearm;
        chk_rd("R1 time before rearm", 5'h00, 32'd715);
        wr(5'h04, 32'd718);
        chk_rd("R9 alarm pending", 5'h14, 32'h2);
        ticks(2);
        chk_irq("R6 below new alarm", 1'b0);
        ticks(1);
        chk_irq("R6 equal new alarm", 1'b0);
        ticks(1);
        chk_rd("R1 time at rearm fire", 5'h00, 32'd719);
        chk_irq("R8 relatched after new alarm", 1'b1);
    endtask

    task automatic t_ignore;
        wr(5'h00, 32'd5);
        chk_rd("R2 time write ignored", 5'h00, 32'd719);
        ticks(2);
        chk_rd("R2 count continues", 5'h00, 32'd721);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h09, 32'd3);
        chk_rd("R10 unused offset", 5'h18, 32'd0);
        chk_rd("R10 high offset", 5'h1C, 32'd0);
        chk_rd("R10 misaligned read", 5'h09, 32'd0);
        chk_rd("R10 load unchanged", 5'h08, 32'd700);
        chk_rd("R10 no pending", 5'h14, 32'h0);
    endtask

    task automatic t_wrap;
        wr(5'h08, 32'hFFFF_FFFE);
        ticks(2);
        chk_rd("R3 near wrap", 5'h00, 32'hFFFF_FFFE);
        ticks(1);
        chk_rd("R1 top value", 5'h00, 32'hFFFF_FFFF);
        ticks(1);
        chk_rd("R1 wraps to zero", 5'h00, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_load();
        t_replace();
        t_alarm_mask();
        t_ack();
        t_rearm();
        t_ignore();
        t_wrap();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule